// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block sits on the controller side of a two-bank synchronous DRAM and owns the device's housekeeping commands. After reset it keeps the command bus at deselect for a startup window. It then closes both banks with a precharge-all and waits out the precharge time. Next it performs a fixed number of auto-refresh cycles, each followed by the full refresh cycle time. Finally it loads the mode register and waits the mode-set recovery time before it reports that initialisation is complete.

Once initialised, it paces refreshes so that 1024 of them fall evenly inside the refresh period. Each time an interval expires it raises a request to the main arbiter. When the arbiter grants, the sequencer closes both banks and then issues an auto-refresh. The bank bit carried with successive refresh commands alternates between the two banks. On every cycle in which it issues no command, the block drives deselect.

Top module: `sdram_initref_seq`

## Requirements
- R1: While reset is asserted, cmd_o is deselect (code 0), addr_o is zero, bank_o is 0, and init_done and refresh_req are low.
- R2: After reset is released, cmd_o stays deselect for T_START cycles. In cycle T_START (counted from 0 at release) it carries precharge (code 1) with addr_o bit AP_BIT set, meaning all banks.
- R3: Every precharge-all is followed, exactly T_RP cycles later, by an auto-refresh (code 2) with addr_o zero.
- R4: During initialisation, N_INIT auto-refreshes are issued T_RC cycles apart. A mode set (code 3) with addr_o equal to MODE_WORD follows T_RC cycles after the last of them.
- R5: init_done rises exactly T_RSC cycles after the mode-set cycle and then stays high until reset.
- R6: After init_done rises, refresh_req rises once every REF_PERIOD/1024 cycles. The first rise comes that many cycles after the first cycle in which init_done is high.
- R7: A cycle in which refresh_req and refresh_grant are both high and the sequencer is idle is followed by a precharge-all in the next cycle. refresh_req drops in that same next cycle.
- R8: While refresh_grant is low, no command is issued after initialisation, and a raised refresh_req stays high.
- R9: bank_o alternates on successive auto-refreshes, starting at 0 after reset. It is 0 on every other command.
- R10: After an auto-refresh, no command other than deselect appears until T_RC cycles have elapsed. Every cycle without a command shows deselect with addr_o zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| refresh_grant | input | 1 | Arbiter permission to run a refresh sequence |
| refresh_req | output | 1 | A refresh interval has expired and is waiting for a grant |
| init_done | output | 1 | Power-up sequence finished; sticky until reset |
| cmd_o | output | 3 | Command: 0 deselect, 1 precharge, 2 auto-refresh, 3 mode set |
| addr_o | output | ADDR_W | Address bus: all-bank flag on precharge, mode word on mode set |
| bank_o | output | 1 | Bank bit, toggled on each auto-refresh |

## Verification
A wrong wait-counter load shows up at the ports as a command that lands a cycle early or late against the precharge, refresh-cycle or mode-set spacing. This is visible on the very next command after the faulty wait. A state machine that loses track of the initial refresh count shows an extra or a missing refresh before the mode set, and init_done moves by a multiple of T_RC. A slip in the refresh interval counter or the request flag drifts refresh_req away from its 64-cycle grid by the time of the first or second post-init request. A stuck bank bit repeats the same bank on two consecutive refreshes.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

  typedef enum logic [2:0] {
    CMD_DESEL = 3'd0,
    CMD_PRE   = 3'd1,
    CMD_REF   = 3'd2,
    CMD_MRS   = 3'd3
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_START, ST_PRE, ST_WRP, ST_REF, ST_WRC, ST_MRS, ST_WRSC, ST_IDLE
  } seq_state_e;

  // cycles between two refresh requests
  function automatic int unsigned ref_interval(int unsigned period, int unsigned nref);
    return period / nref;
  endfunction

  // a wait of t cycles from a command: one command cycle plus (load+1) wait cycles
  function automatic int unsigned wait_load(int unsigned t);
    return t - 2;
  endfunction

  function automatic int unsigned bits_for(int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdseq_wait_timer.sv
module sdseq_wait_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= W'(RST_VAL);
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdseq_refresh_timer.sv
module sdseq_refresh_timer #(
  parameter int INTERVAL = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic tick_o
);
  localparam int W = (INTERVAL < 2) ? 1 : $clog2(INTERVAL);
  localparam logic [W-1:0] RELOAD = W'(INTERVAL - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= RELOAD;
    else if (!enable)        cnt_q <= RELOAD;
    else if (cnt_q == '0)    cnt_q <= RELOAD;
    else                     cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = enable && (cnt_q == '0);
endmodule

// File: rtl/sdseq_cmd_drive.sv
module sdseq_cmd_drive
  import sdseq_pkg::*;
#(
  parameter int              ADDR_W    = 9,
  parameter int              AP_BIT    = 8,
  parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
  input  seq_state_e        state_i,
  input  logic              bank_i,
  output sd_cmd_e           cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              bank_o
);
  always_comb begin
    cmd_o  = CMD_DESEL;
    addr_o = '0;
    bank_o = 1'b0;
    unique case (state_i)
      ST_PRE: begin
        cmd_o          = CMD_PRE;
        addr_o[AP_BIT] = 1'b1;
      end
      ST_REF: begin
        cmd_o  = CMD_REF;
        bank_o = bank_i;
      end
      ST_MRS: begin
        cmd_o  = CMD_MRS;
        addr_o = MODE_WORD;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sdram_initref_seq.sv
module sdram_initref_seq
  import sdseq_pkg::*;
#(
  parameter int                T_START         = 20,
  parameter int                T_RP            = 3,
  parameter int                T_RC            = 6,
  parameter int                T_RSC           = 2,
  parameter int                N_INIT          = 2,
  parameter int                REF_PERIOD      = 65536,
  parameter int                REFS_PER_PERIOD = 1024,
  parameter int                ADDR_W          = 9,
  parameter int                AP_BIT          = 8,
  parameter logic [ADDR_W-1:0] MODE_WORD       = 9'h032
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refresh_grant,
  output logic              refresh_req,
  output logic              init_done,
  output logic [2:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              bank_o
);
  localparam int INTERVAL = ref_interval(REF_PERIOD, REFS_PER_PERIOD);
  localparam int WAIT_MAX = max2(max2(T_START, T_RP), max2(T_RC, T_RSC));
  localparam int WAIT_W   = bits_for(WAIT_MAX);
  localparam int INIT_W   = bits_for(N_INIT);

  localparam logic [WAIT_W-1:0] LD_RP  = WAIT_W'(wait_load(T_RP));
  localparam logic [WAIT_W-1:0] LD_RC  = WAIT_W'(wait_load(T_RC));
  localparam logic [WAIT_W-1:0] LD_RSC = WAIT_W'(wait_load(T_RSC));

  seq_state_e        state_q, state_d;
  logic              wait_zero, wait_load_en;
  logic [WAIT_W-1:0] wait_val;
  logic [INIT_W-1:0] init_refs_q;
  logic              bank_q;
  logic              tick;
  sd_cmd_e           cmd_e;

  // named events for the checker
  logic seq_idle;
  logic grant_accept;
  assign seq_idle     = (state_q == ST_IDLE);
  assign grant_accept = seq_idle && refresh_req && refresh_grant;

  sdseq_wait_timer #(.W(WAIT_W), .RST_VAL(T_START - 1)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(wait_load_en), .load_val(wait_val), .zero_o(wait_zero)
  );

  sdseq_refresh_timer #(.INTERVAL(INTERVAL)) u_rtim (
    .clk(clk), .rst_n(rst_n), .enable(init_done), .tick_o(tick)
  );

  sdseq_cmd_drive #(.ADDR_W(ADDR_W), .AP_BIT(AP_BIT), .MODE_WORD(MODE_WORD)) u_drv (
    .state_i(state_q), .bank_i(bank_q), .cmd_o(cmd_e), .addr_o(addr_o), .bank_o(bank_o)
  );

  assign cmd_o = cmd_e;

  always_comb begin
    wait_load_en = 1'b0;
    wait_val     = '0;
    unique case (state_q)
      ST_PRE:  begin wait_load_en = 1'b1; wait_val = LD_RP;  end
      ST_REF:  begin wait_load_en = 1'b1; wait_val = LD_RC;  end
      ST_MRS:  begin wait_load_en = 1'b1; wait_val = LD_RSC; end
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_START: if (wait_zero) state_d = ST_PRE;
      ST_PRE:   state_d = ST_WRP;
      ST_WRP:   if (wait_zero) state_d = ST_REF;
      ST_REF:   state_d = ST_WRC;
      ST_WRC: begin
        if (wait_zero) begin
          if (init_done)                          state_d = ST_IDLE;
          else if (init_refs_q == INIT_W'(N_INIT)) state_d = ST_MRS;
          else                                    state_d = ST_REF;
        end
      end
      ST_MRS:   state_d = ST_WRSC;
      ST_WRSC:  if (wait_zero) state_d = ST_IDLE;
      ST_IDLE:  if (grant_accept) state_d = ST_PRE;
      default:  state_d = ST_START;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_START;
      init_refs_q <= '0;
      bank_q      <= 1'b0;
      init_done   <= 1'b0;
      refresh_req <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_REF) begin
        bank_q <= ~bank_q;
        if (!init_done) init_refs_q <= init_refs_q + 1'b1;
      end
      if (state_q == ST_WRSC && wait_zero) init_done <= 1'b1;
      refresh_req <= tick || (refresh_req && !grant_accept);
    end
  end
endmodule

// File: rtl/sdseq_chk.sv
module sdseq_chk
  import sdseq_pkg::*;
#(
  parameter int T_RP   = 3,
  parameter int T_RC   = 6,
  parameter int ADDR_W = 9,
  parameter int AP_BIT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              refresh_grant,
  input logic              refresh_req,
  input logic              init_done,
  input logic [2:0]        cmd_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              bank_o,
  input logic              seq_idle
);
  localparam int SAT = T_RP + T_RC;
  localparam int CW  = $clog2(SAT + 2);

  logic [CW-1:0] since_pre, since_ref;
  logic          last_bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_pre <= CW'(SAT);
      since_ref <= CW'(SAT);
      last_bank <= 1'b1;
    end else begin
      if (cmd_o == CMD_PRE)              since_pre <= CW'(1);
      else if (since_pre < CW'(SAT))     since_pre <= since_pre + 1'b1;
      if (cmd_o == CMD_REF) begin
        since_ref <= CW'(1);
        last_bank <= bank_o;
      end else if (since_ref < CW'(SAT)) since_ref <= since_ref + 1'b1;
    end
  end

  a_r2_pre_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_PRE) |-> addr_o[AP_BIT]);

  a_r3_ref_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_REF) |-> (since_pre == CW'(T_RP) || since_ref == CW'(T_RC)));

  a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  a_r7_pre_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_idle && refresh_req && refresh_grant) |=> (cmd_o == CMD_PRE && !refresh_req));

  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !refresh_grant) |=> refresh_req);

  a_r9_bank_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_REF) |-> (bank_o != last_bank));

  a_r10_quiet_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != CMD_DESEL) |-> (since_ref >= CW'(T_RC)));
endmodule

bind sdram_initref_seq sdseq_chk #(
  .T_RP(T_RP), .T_RC(T_RC), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .refresh_grant(refresh_grant), .refresh_req(refresh_req),
  .init_done(init_done), .cmd_o(cmd_o), .addr_o(addr_o), .bank_o(bank_o),
  .seq_idle(seq_idle)
);

// File: tb/tb_sdram_initref_seq.sv
`timescale 1ns/1ps
module tb_sdram_initref_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       refresh_grant = 1'b1;
  logic       refresh_req, init_done, bank_o;
  logic [2:0] cmd_o;
  logic [8:0] addr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  sdram_initref_seq dut (
    .clk(clk), .rst_n(rst_n), .refresh_grant(refresh_grant), .refresh_req(refresh_req),
    .init_done(init_done), .cmd_o(cmd_o), .addr_o(addr_o), .bank_o(bank_o)
  );

  // expected command events: cycle, code, address, bank
  typedef struct packed {
    int         cyc;
    logic [2:0] cmd;
    logic [8:0] addr;
    logic       bank;
  } ev_t;

  localparam int NEV = 12;
  localparam ev_t EVT [NEV] = '{
    '{20,  3'd1, 9'h100, 1'b0},   // R2 precharge-all
    '{23,  3'd2, 9'h000, 1'b0},   // R3 first init refresh
    '{29,  3'd2, 9'h000, 1'b1},   // R4 second init refresh
    '{35,  3'd3, 9'h032, 1'b0},   // R4 mode set
    '{102, 3'd1, 9'h100, 1'b0},   // R7
    '{105, 3'd2, 9'h000, 1'b0},   // R3 R9
    '{166, 3'd1, 9'h100, 1'b0},
    '{169, 3'd2, 9'h000, 1'b1},
    '{230, 3'd1, 9'h100, 1'b0},
    '{233, 3'd2, 9'h000, 1'b0},
    '{323, 3'd1, 9'h100, 1'b0},   // R8 late grant
    '{326, 3'd2, 9'h000, 1'b1}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    int idx = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cmd", int'(cmd_o), 0);
    chk("R1 init_done", int'(init_done), 0);
    chk("R1 refresh_req", int'(refresh_req), 0);
    chk("R1 addr", int'(addr_o), 0);
    rst_n = 1'b1;
    for (int c = 0; c <= 330; c++) begin
      if (cmd_o != 3'd0) begin
        if (idx < NEV) begin
          chk("R2/R3/R4/R7 cycle", c, EVT[idx].cyc);
          chk("R2/R4 code", int'(cmd_o), int'(EVT[idx].cmd));
          chk("R4 addr", int'(addr_o), int'(EVT[idx].addr));
          chk("R9 bank", int'(bank_o), int'(EVT[idx].bank));
        end else chk("R10 extra command", c, -1);
        idx++;
      end else begin
        if (addr_o != 9'd0 || bank_o != 1'b0) chk("R10 idle bus", int'(addr_o), 0);
      end
      if (c == 36)  chk("R5 init_done before", int'(init_done), 0);
      if (c == 37)  chk("R5 init_done after", int'(init_done), 1);
      if (c == 300) chk("R5 init_done sticky", int'(init_done), 1);
      if (c == 100) chk("R6 req before", int'(refresh_req), 0);
      if (c == 101) chk("R6 req first", int'(refresh_req), 1);
      if (c == 102) chk("R7 req drop", int'(refresh_req), 0);
      if (c == 164) chk("R6 req gap", int'(refresh_req), 0);
      if (c == 165) chk("R6 req second", int'(refresh_req), 1);
      if (c == 292) chk("R6 req fourth pre", int'(refresh_req), 0);
      if (c == 293) chk("R8 req raised", int'(refresh_req), 1);
      if (c == 322) chk("R8 req held", int'(refresh_req), 1);
      if (c == 323) chk("R7 req cleared", int'(refresh_req), 0);
      if (c == 260) refresh_grant = 1'b0;
      if (c == 322) refresh_grant = 1'b1;
      @(negedge clk);
    end
    chk("R10 event count", idx, NEV);

    // directed: reset in the middle of operation
    rst_n = 1'b0;
    #1;
    chk("R1 mid reset init_done", int'(init_done), 0);
    chk("R1 mid reset req", int'(refresh_req), 0);
    chk("R1 mid reset cmd", int'(cmd_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idx = 0;
    for (int c = 0; c <= 24; c++) begin
      if (cmd_o != 3'd0) begin
        if (idx == 0) begin
          chk("R2 restart PRE cycle", c, 20);
          chk("R2 restart all-bank", int'(addr_o[8]), 1);
        end else if (idx == 1) begin
          chk("R3 restart REF cycle", c, 23);
          chk("R9 restart bank", int'(bank_o), 0);
        end
        idx++;
      end
      @(negedge clk);
    end
    chk("R2 restart events", idx, 2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule